// File: doc/BRIEF.md
# Chroma Gain Control with Burst AGC

This block scales a stream of Cb and Cr colour-difference samples by a gain. Software picks one of four modes: a unity pass-through, an automatic gain taken from the measured colour burst, a gain taken from a fixed register, or a frozen copy of the last automatic gain. Samples swing around the 128 midpoint. After scaling, each result is clipped to the legal chroma range of 16 to 240.

In automatic mode an upstream burst detector sends one amplitude value per line, together with a one-cycle valid strobe. It sends nothing on lines that have no burst. The block averages the newest amplitude with the two previous strobed amplitudes. It then sets the gain to the nominal amplitude divided by that average, so that the burst is brought back to its nominal size. The gain is unsigned fixed point with 2 integer bits and 6 fractional bits, so code 64 means 1x. The active gain is also driven out so that other logic can watch it.

Top module: `chroma_gain_ctrl`

## Requirements
- R1: During synchronous active-low reset and in the first cycle after it:
  - cb_o and cr_o read 128.
  - The burst history and the average start at the nominal amplitude (default 80). This makes the automatic gain 64.
  - The frozen gain starts at 64.
- R2: When mode_i is 0 (unity), gain_o is 64. Each output then equals the input sample from the previous cycle, clipped to 16..240.
- R3: When mode_i is 1 (automatic), gain_o follows the registered average, which is updated on the clock edge where burst_vld_i is high:
  - The average is floor((new amplitude + previous strobed amplitude + the one before it) / 3).
  - gain_o is floor(nominal*64 / average), clamped as in R4.
  - The new gain appears in the cycle after the strobe.
- R4: The automatic gain and the fixed gain are both clamped to the range 32 (0.5x) to 255. Code 255 is the largest code and stands for roughly 4x.
- R5: When mode_i is 2 (fixed), gain_o is fixed_gain_i, clamped as in R4. Burst strobes have no effect on the gain in this mode.
- R6: When mode_i is 3 (freeze), gain_o holds the automatic gain from the last cycle before freeze was entered. It stays at that value however many bursts arrive.
- R7: If the three-line average is 0, the automatic gain is 255.
- R8: Each output in cycle n+1 is clip(128 + floor(((x - 128) * g + 32) / 64), 16, 240). Here x is the input sample and g is gain_o, both taken in cycle n.
- R9: A cycle without burst_vld_i leaves the history, the average and the automatic gain unchanged, whatever burst_amp_i carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Gain mode: 0 unity, 1 automatic, 2 fixed, 3 freeze |
| fixed_gain_i | input | 8 | Fixed gain register value, Q2.6 |
| burst_amp_i | input | 8 | Measured burst amplitude for the current line |
| burst_vld_i | input | 1 | One-cycle strobe: burst_amp_i is valid |
| cb_i | input | 8 | Cb sample in |
| cr_i | input | 8 | Cr sample in |
| cb_o | output | 8 | Scaled and clipped Cb |
| cr_o | output | 8 | Scaled and clipped Cr |
| gain_o | output | 8 | Gain in use, Q2.6 |

## Verification
The assertions assume that mode_i and fixed_gain_i are static between clock edges. The unity-transparency property also assumes that an input sample is already inside 16..240 before it can be expected back unchanged; samples outside that range are only subject to the range check. Freeze holding is asserted only over cycles in which mode_i stays at freeze. The stimulus changes inputs just after a rising edge, strobes bursts on isolated cycles with junk amplitudes between them, and holds each mode for a run of cycles so that these assumptions hold.

// File: rtl/cgc_pkg.sv
// Shared types for the chroma gain control block.
// Assumes the mode select is presented as a 2-bit code.
package cgc_pkg;
    typedef enum logic [1:0] {
        GM_UNITY  = 2'd0,
        GM_AUTO   = 2'd1,
        GM_FIXED  = 2'd2,
        GM_FREEZE = 2'd3
    } gain_mode_e;
endpackage

// File: rtl/cgc_burst_avg.sv
// Three-line burst amplitude averager.
// Keeps the two most recent strobed amplitudes. On each strobe it registers the
// mean of the new amplitude and those two, then shifts the history.
// Assumes the strobe is high for one cycle per burst-bearing line.
module cgc_burst_avg #(
    parameter int AMP_W   = 8,
    parameter int NOMINAL = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AMP_W-1:0] amp_i,
    input  logic             amp_vld_i,
    output logic [AMP_W-1:0] avg_o
);
    localparam int SUM_W = AMP_W + 2;
    localparam logic [AMP_W-1:0] NOM_V = AMP_W'(NOMINAL);

    logic [AMP_W-1:0] hist_q [2];
    logic [AMP_W-1:0] avg_q;
    logic [SUM_W-1:0] sum_c;

    // Sum of the new amplitude and the two stored ones.
    always_comb begin
        sum_c = SUM_W'(amp_i) + SUM_W'(hist_q[0]) + SUM_W'(hist_q[1]);
    end

    // Update the history and the average only on strobed lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q[0] <= NOM_V;
            hist_q[1] <= NOM_V;
            avg_q     <= NOM_V;
        end else if (amp_vld_i) begin
            hist_q[0] <= amp_i;
            hist_q[1] <= hist_q[0];
            avg_q     <= AMP_W'(sum_c / SUM_W'(3));
        end
    end

    assign avg_o = avg_q;

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !amp_vld_i |=> $stable(avg_q)); // R9
endmodule

// File: rtl/cgc_gain_select.sv
// Gain source selection.
// Computes the automatic gain from the burst average and clamps the fixed
// register. It keeps a frozen copy of the automatic gain, which it refreshes
// on every cycle that is not in freeze mode. It then drives the gain of the
// selected mode. Gain is unsigned Q2.FRAC.
module cgc_gain_select
    import cgc_pkg::*;
#(
    parameter int AMP_W   = 8,
    parameter int GAIN_W  = 8,
    parameter int FRAC    = 6,
    parameter int NOMINAL = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [GAIN_W-1:0] fixed_i,
    input  logic [AMP_W-1:0]  avg_i,
    output logic [GAIN_W-1:0] gain_o
);
    localparam int QW = AMP_W + FRAC + 2;
    localparam logic [QW-1:0]     NUM   = QW'(NOMINAL) << FRAC;
    localparam logic [GAIN_W-1:0] GMIN  = GAIN_W'(1 << (FRAC - 1));
    localparam logic [GAIN_W-1:0] GMAX  = {GAIN_W{1'b1}};
    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << FRAC);

    gain_mode_e        mode;
    logic [QW-1:0]     quot_c;
    logic [GAIN_W-1:0] auto_c;
    logic [GAIN_W-1:0] fixed_c;
    logic [GAIN_W-1:0] frz_q;

    assign mode = gain_mode_e'(mode_i);

    // Automatic gain: nominal over average, clamped; a zero average gives the maximum.
    always_comb begin
        quot_c = '0;
        if (avg_i == '0) begin
            auto_c = GMAX;
        end else begin
            quot_c = NUM / QW'(avg_i);
            if (quot_c < QW'(GMIN))      auto_c = GMIN;
            else if (quot_c > QW'(GMAX)) auto_c = GMAX;
            else                         auto_c = quot_c[GAIN_W-1:0];
        end
    end

    // Fixed gain: raise values below the minimum.
    always_comb begin
        fixed_c = (fixed_i < GMIN) ? GMIN : fixed_i;
    end

    // Frozen copy: track the automatic gain until freeze mode is entered.
    always_ff @(posedge clk) begin
        if (!rst_n)                 frz_q <= UNITY;
        else if (mode != GM_FREEZE) frz_q <= auto_c;
    end

    // Drive the gain of the selected mode.
    always_comb begin
        unique case (mode)
            GM_UNITY:  gain_o = UNITY;
            GM_AUTO:   gain_o = auto_c;
            GM_FIXED:  gain_o = fixed_c;
            default:   gain_o = frz_q;
        endcase
    end

    AST_GAIN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != GM_UNITY) |-> (gain_o >= GMIN)); // R4
    AST_ZERO_AVG_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == GM_AUTO && avg_i == '0) |-> (gain_o == GMAX)); // R7
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == GM_FREEZE) |=> (mode != GM_FREEZE || $stable(gain_o))); // R6
endmodule

// File: rtl/cgc_scaler.sv
// One colour-difference channel scaler.
// Multiplies the offset from the midpoint by the gain, rounds at FRAC bits,
// restores the midpoint and clips to the legal range. One register stage.
module cgc_scaler #(
    parameter int DATA_W  = 8,
    parameter int GAIN_W  = 8,
    parameter int FRAC    = 6,
    parameter int CLIP_LO = 16,
    parameter int CLIP_HI = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [GAIN_W-1:0] gain_i,
    output logic [DATA_W-1:0] sample_o
);
    localparam int PW  = DATA_W + GAIN_W + 4;
    localparam int MID = 1 << (DATA_W - 1);
    localparam logic signed [PW-1:0] MID_S  = PW'(MID);
    localparam logic signed [PW-1:0] HALF_S = PW'(1 << (FRAC - 1));
    localparam logic signed [PW-1:0] LO_S   = PW'(CLIP_LO);
    localparam logic signed [PW-1:0] HI_S   = PW'(CLIP_HI);
    localparam logic [DATA_W-1:0] LO_V  = DATA_W'(CLIP_LO);
    localparam logic [DATA_W-1:0] HI_V  = DATA_W'(CLIP_HI);
    localparam logic [DATA_W-1:0] MID_V = DATA_W'(MID);

    logic signed [PW-1:0] diff_c, gain_c, prod_c, res_c;
    logic [DATA_W-1:0]    clip_c, out_q;

    // Offset, multiply, round, re-centre and clip.
    always_comb begin
        diff_c = $signed({{(PW-DATA_W){1'b0}}, sample_i}) - MID_S;
        gain_c = $signed({{(PW-GAIN_W){1'b0}}, gain_i});
        prod_c = diff_c * gain_c;
        res_c  = ((prod_c + HALF_S) >>> FRAC) + MID_S;
        if (res_c < LO_S)      clip_c = LO_V;
        else if (res_c > HI_S) clip_c = HI_V;
        else                   clip_c = res_c[DATA_W-1:0];
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= MID_V;
        else        out_q <= clip_c;
    end

    assign sample_o = out_q;

    AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q >= LO_V) && (out_q <= HI_V)); // R8
endmodule

// File: rtl/chroma_gain_ctrl.sv
// Chroma gain control top.
// Averages the burst amplitude, selects the gain by mode, and scales Cb and Cr
// through two identical scaler channels. The output samples lag the input by
// one cycle. gain_o is combinational from registered state and the mode and
// fixed-gain inputs.
module chroma_gain_ctrl
    import cgc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int AMP_W   = 8,
    parameter int GAIN_W  = 8,
    parameter int FRAC    = 6,
    parameter int NOMINAL = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [GAIN_W-1:0] fixed_gain_i,
    input  logic [AMP_W-1:0]  burst_amp_i,
    input  logic              burst_vld_i,
    input  logic [DATA_W-1:0] cb_i,
    input  logic [DATA_W-1:0] cr_i,
    output logic [DATA_W-1:0] cb_o,
    output logic [DATA_W-1:0] cr_o,
    output logic [GAIN_W-1:0] gain_o
);
    localparam int NCH = 2;

    logic [AMP_W-1:0]  avg;
    logic [GAIN_W-1:0] gain;
    logic [DATA_W-1:0] ch_in  [NCH];
    logic [DATA_W-1:0] ch_out [NCH];

    cgc_burst_avg #(.AMP_W(AMP_W), .NOMINAL(NOMINAL)) u_avg (
        .clk(clk), .rst_n(rst_n), .amp_i(burst_amp_i),
        .amp_vld_i(burst_vld_i), .avg_o(avg)
    );

    cgc_gain_select #(.AMP_W(AMP_W), .GAIN_W(GAIN_W), .FRAC(FRAC),
                      .NOMINAL(NOMINAL)) u_sel (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .fixed_i(fixed_gain_i),
        .avg_i(avg), .gain_o(gain)
    );

    assign ch_in[0] = cb_i;
    assign ch_in[1] = cr_i;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        cgc_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .FRAC(FRAC)) u_scl (
            .clk(clk), .rst_n(rst_n), .sample_i(ch_in[c]),
            .gain_i(gain), .sample_o(ch_out[c])
        );
    end

    assign cb_o   = ch_out[0];
    assign cr_o   = ch_out[1];
    assign gain_o = gain;

    AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_mode_e'(mode_i) == GM_UNITY && cb_i >= DATA_W'(16) && cb_i <= DATA_W'(240))
        |=> (cb_o == $past(cb_i))); // R2
endmodule

// File: tb/chroma_gain_ctrl_test.sv
`timescale 1ns/1ps
module chroma_gain_ctrl_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [1:0] mode_i = 0;
    logic [7:0] fixed_gain_i = 64;
    logic [7:0] burst_amp_i = 0;
    logic       burst_vld_i = 0;
    logic [7:0] cb_i = 128, cr_i = 128;
    logic [7:0] cb_o, cr_o, gain_o;

    int tests = 0, fails = 0;
    int h1 = 80, h2 = 80, avg = 80, frz = 64;
    int exp_cb = 128, exp_cr = 128;
    bit ready = 0;
    bit done = 0;

    chroma_gain_ctrl uut (.*);

    always #2.5 clk = ~clk;

    function automatic int auto_g(int a);
        int q;
        if (a == 0) return 255;
        q = 5120 / a;
        if (q < 32) return 32;
        if (q > 255) return 255;
        return q;
    endfunction

    function automatic int model_gain(int m, int f);
        case (m)
            0: return 64;
            1: return auto_g(avg);
            2: return (f < 32) ? 32 : f;
            default: return frz;
        endcase
    endfunction

    function automatic int scale(int x, int g);
        int p, r;
        p = (x - 128) * g + 32;
        r = 128 + (p >>> 6);
        if (r < 16) return 16;
        if (r > 240) return 240;
        return r;
    endfunction

    function automatic string mode_tag(int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(string tag, int act, int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    // Reference model: advance on each rising edge from inputs that are stable there.
    always @(posedge clk) begin
        int g;
        g = model_gain(mode_i, fixed_gain_i);
        if (!rst_n) begin
            exp_cb = 128; exp_cr = 128;
            h1 = 80; h2 = 80; avg = 80; frz = 64;
            ready = 1;
        end else begin
            exp_cb = scale(cb_i, g);
            exp_cr = scale(cr_i, g);
            if (mode_i != 3) frz = auto_g(avg);
            if (burst_vld_i) begin
                avg = (burst_amp_i + h1 + h2) / 3;
                h2 = h1;
                h1 = burst_amp_i;
            end
        end
    end

    // Compare all outputs on every falling edge.
    always @(negedge clk) begin
        if (ready && !done) begin
            chk("R8", cb_o, exp_cb);
            chk("R8", cr_o, exp_cr);
            chk(mode_tag(mode_i), gain_o, model_gain(mode_i, fixed_gain_i));
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic burst(int a);
        burst_amp_i = 8'(a); burst_vld_i = 1;
        cb_i = 8'($urandom_range(0, 255)); cr_i = 8'($urandom_range(0, 255));
        step();
        burst_vld_i = 0; burst_amp_i = 8'($urandom_range(0, 255));
        for (int i = 0; i < 3; i++) begin
            cb_i = 8'($urandom_range(0, 255)); cr_i = 8'($urandom_range(0, 255));
            step();
        end
    endtask

    task automatic samples(int n);
        for (int i = 0; i < n; i++) begin
            cb_i = 8'($urandom_range(0, 255)); cr_i = 8'($urandom_range(0, 255));
            burst_amp_i = 8'($urandom_range(0, 255));
            step();
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int held;
        mode_i = 1;
        step(3);
        #1;
        chk("R1", cb_o, 128); chk("R1", cr_o, 128); chk("R1", gain_o, 64);
        rst_n = 1;
        #1;
        chk("R1", gain_o, 64);
        // Unity mode, including values that clip.
        mode_i = 0;
        foreach (cb_i[k]) ;
        cb_i = 0; cr_i = 255; step();
        cb_i = 16; cr_i = 240; step();
        samples(20);
        #1; chk("R2", cb_o, exp_cb);
        // Automatic mode with a range of bursts.
        mode_i = 1;
        burst(40); burst(40); burst(40);
        #1; chk("R3", gain_o, 128);
        burst(120); burst(100);
        // Junk amplitudes without strobe leave the gain unchanged.
        held = gain_o;
        samples(10);
        #1; chk("R9", gain_o, held);
        // Zero average gives the maximum.
        burst(0); burst(0); burst(0);
        #1; chk("R7", gain_o, 255);
        // Large bursts clamp to the minimum.
        burst(250); burst(250); burst(250);
        #1; chk("R4", gain_o, 32);
        burst(50); burst(60); burst(70);
        // Freeze: gain held while new bursts arrive.
        held = gain_o;
        mode_i = 3;
        burst(10); burst(200); burst(30);
        samples(5);
        #1; chk("R6", gain_o, held);
        // Fixed mode ignores bursts; low values are clamped.
        mode_i = 2;
        fixed_gain_i = 5;  burst(90);
        #1; chk("R4", gain_o, 32);
        fixed_gain_i = 100; burst(20); samples(5);
        #1; chk("R5", gain_o, 100);
        fixed_gain_i = 255; burst(0); samples(5);
        #1; chk("R5", gain_o, 255);
        // Back to automatic: history kept updating in fixed mode.
        mode_i = 1;
        samples(5);
        for (int i = 0; i < 40; i++) begin
            mode_i = 2'($urandom_range(0, 3));
            fixed_gain_i = 8'($urandom_range(0, 255));
            burst($urandom_range(0, 255));
        end
        step(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule